// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block owns the 32-bit program counter of a simple in-order core and picks the counter's next value on every clock edge. The decoder hands it the decoded fields of the current instruction: the primary opcode, the function code, a 16-bit branch offset and a 26-bit jump target. The register file hands it the two values read for the instruction. From these the unit chooses among plain sequential flow, two compare-and-branch forms, a jump within the current 256 MiB address region, a call that also produces a return address, and an indirect jump through a register.

A stall input freezes the counter so that a stalled pipeline does not lose its place. For a call, the unit also provides the return address and a write strobe for the link register, so the register file can store the return address. Delay slots, exceptions and instruction fetch belong to other blocks.

Top module: `nextPcUnit`

## Requirements
- R1: While the active-low reset `rstN` is low, `pc` is forced to zero at once, without waiting for a clock edge.
- R2: On a rising edge with `stall` low, the counter advances by 4 for any opcode other than 2, 3, 4 and 5, except opcode 0 with function code 8. This includes opcode 0 with any other function code.
- R3: Opcode 4 compares `rsVal` with `rtVal`. When they are equal, the next `pc` is pc + 4 + 4 × (the 16-bit `offset` sign-extended). When they differ, the next `pc` is pc + 4.
- R4: Opcode 5 takes the branch with the same target formula when `rsVal` and `rtVal` differ. When they are equal, the next `pc` is pc + 4.
- R5: Opcode 2 loads `pc` with the top 4 bits of pc + 4 in bits 31..28, the 26-bit `target` in bits 27..2, and zeros in bits 1..0.
- R6: Opcode 3 performs the same jump as opcode 2. `linkAddr` always shows the current pc + 4, combinationally, so it carries the return address in the cycle of the call.
- R7: Opcode 0 with function code 8 loads `pc` with `rsVal` unchanged.
- R8: `linkWe` is high in exactly the cycles where the opcode is 3 and `stall` is low. It is combinational.
- R9: With `stall` high, `pc` keeps its value across the edge, whatever the instruction inputs are.
- R10: Every change of `pc` takes effect on the rising edge that ends the cycle in which the instruction fields were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Holds the counter when high |
| opcode | input | 6 | Primary opcode of the current instruction |
| funct | input | 6 | Function code of the current instruction |
| offset | input | 16 | Signed branch offset, counted in words |
| target | input | 26 | Jump target, counted in words |
| rsVal | input | 32 | First register read value; compare operand and indirect target |
| rtVal | input | 32 | Second register read value; compare operand |
| pc | output | 32 | Current program counter |
| linkAddr | output | 32 | Current pc + 4, the return address |
| linkWe | output | 1 | Write strobe for the link register |

## Verification
`linkAddr` and `linkWe` depend only on the current counter and the current inputs. The bench therefore samples them a short settle time after it drives a new instruction, inside the same cycle. A new `pc` is due one rising edge after the instruction is presented. The bench samples it at the falling edge that follows that rising edge, before it drives the next instruction. For every cycle, a behavioural model in the bench predicts both results and compares them. Directed cycles cover negative and extreme offsets, a jump whose pc + 4 wraps into region 0, and stalls held over each kind of instruction.

// File: rtl/npcPkg.sv
package npcPkg;

  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_JUMP    = 6'd2;
  localparam logic [5:0] OPC_CALL    = 6'd3;
  localparam logic [5:0] OPC_BREQ    = 6'd4;
  localparam logic [5:0] OPC_BRNE    = 6'd5;
  localparam logic [5:0] FN_JREG     = 6'd8;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_JMP  = 2'd2,
    SEL_JREG = 2'd3
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   hold;
    logic   linkWe;
  } ctlStrobes_t;

endpackage

// File: rtl/npcControl.sv
module npcControl
  import npcPkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stall,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  input  logic            regsEqual,
  output ctlStrobes_t     ctl
);

  logic isBrEq;
  logic isBrNe;
  logic isJump;
  logic isCall;
  logic isJReg;
  logic brTaken;

  always_comb begin
    isBrEq  = (opcode == OP_W'(OPC_BREQ));
    isBrNe  = (opcode == OP_W'(OPC_BRNE));
    isJump  = (opcode == OP_W'(OPC_JUMP));
    isCall  = (opcode == OP_W'(OPC_CALL));
    isJReg  = (opcode == OP_W'(OPC_SPECIAL)) && (funct == FN_W'(FN_JREG));
    brTaken = (isBrEq && regsEqual) || (isBrNe && !regsEqual);
  end

  always_comb begin
    ctl.hold   = stall;
    ctl.linkWe = isCall && !stall;
    if (brTaken)               ctl.pcSel = SEL_BR;
    else if (isJump || isCall) ctl.pcSel = SEL_JMP;
    else if (isJReg)           ctl.pcSel = SEL_JREG;
    else                       ctl.pcSel = SEL_SEQ;
  end

  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.linkWe |-> (opcode == OP_W'(OPC_CALL) && !stall)); // R8
  AST_BREQ_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_W'(OPC_BREQ) && regsEqual) |-> (ctl.pcSel == SEL_BR)); // R3
  AST_BRNE_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_W'(OPC_BRNE) && !regsEqual) |-> (ctl.pcSel == SEL_BR)); // R4

endmodule

// File: rtl/npcDatapath.sv
module npcDatapath
  import npcPkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          OFF_W    = 16,
  parameter int          TGT_W    = 26,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [OFF_W-1:0] offset,
  input  logic [TGT_W-1:0] target,
  input  logic [PC_W-1:0]  rsVal,
  input  logic [PC_W-1:0]  rtVal,
  output logic             regsEqual,
  output logic [PC_W-1:0]  pcQ,
  output logic [PC_W-1:0]  pcPlus4
);

  localparam int REGION_W = PC_W - TGT_W - 2;
  localparam int EXT_W    = PC_W - OFF_W - 2;

  logic [PC_W-1:0] brOffset;
  logic [PC_W-1:0] brTarget;
  logic [PC_W-1:0] jmpTarget;
  logic [PC_W-1:0] pcNext;

  always_comb begin
    regsEqual = (rsVal == rtVal);
    pcPlus4   = pcQ + PC_W'(4);
    brOffset  = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    brTarget  = pcPlus4 + brOffset;
    jmpTarget = {pcPlus4[PC_W-1 -: REGION_W], target, 2'b00};
  end

  always_comb begin
    unique case (ctl.pcSel)
      SEL_BR:   pcNext = brTarget;
      SEL_JMP:  pcNext = jmpTarget;
      SEL_JREG: pcNext = rsVal;
      default:  pcNext = pcPlus4;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pcQ <= PC_W'(RESET_PC);
    else if (!ctl.hold) pcQ <= pcNext;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> $stable(pcQ)); // R9
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.hold && ctl.pcSel == SEL_SEQ) |=> (pcQ == $past(pcQ) + PC_W'(4))); // R2
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.hold && ctl.pcSel == SEL_JMP) |=>
      (pcQ[PC_W-1 -: REGION_W] == $past(pcPlus4[PC_W-1 -: REGION_W]) && pcQ[1:0] == 2'b00)); // R5
  AST_JREG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.hold && ctl.pcSel == SEL_JREG) |=> (pcQ == $past(rsVal))); // R7

endmodule

// File: rtl/nextPcUnit.sv
module nextPcUnit
  import npcPkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          OP_W     = 6,
  parameter int          FN_W     = 6,
  parameter int          OFF_W    = 16,
  parameter int          TGT_W    = 26,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stall,
  input  logic [OP_W-1:0]  opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic [OFF_W-1:0] offset,
  input  logic [TGT_W-1:0] target,
  input  logic [PC_W-1:0]  rsVal,
  input  logic [PC_W-1:0]  rtVal,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  linkAddr,
  output logic             linkWe
);

  ctlStrobes_t ctl;
  logic        regsEqual;

  npcControl #(.OP_W(OP_W), .FN_W(FN_W)) i_control (
    .clk(clk), .rstN(rstN), .stall(stall), .opcode(opcode), .funct(funct),
    .regsEqual(regsEqual), .ctl(ctl)
  );

  npcDatapath #(.PC_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W), .RESET_PC(RESET_PC)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .offset(offset), .target(target),
    .rsVal(rsVal), .rtVal(rtVal), .regsEqual(regsEqual), .pcQ(pc), .pcPlus4(linkAddr)
  );

  assign linkWe = ctl.linkWe;

  AST_RESET_ZERO: assert property (@(posedge clk) !rstN |-> (pc == PC_W'(RESET_PC))); // R1

endmodule

// File: tb/test_nextPcUnit.sv
module test_nextPcUnit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [15:0] offset = '0;
  logic [25:0] target = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [31:0] pc;
  logic [31:0] linkAddr;
  logic        linkWe;

  int errors = 0;
  int checks = 0;
  logic [31:0] mPc = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nextPcUnit i_nextPcUnit (
    .clk(clk), .rstN(rstN), .stall(stall), .opcode(opcode), .funct(funct),
    .offset(offset), .target(target), .rsVal(rsVal), .rtVal(rtVal),
    .pc(pc), .linkAddr(linkAddr), .linkWe(linkWe)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one instruction at a falling edge, check the same-cycle outputs,
  // then check the counter at the next falling edge.
  task automatic step(input logic [5:0] op, input logic [5:0] fn, input logic [15:0] off,
                      input logic [25:0] tgt, input logic [31:0] rs, input logic [31:0] rt,
                      input logic st);
    logic [31:0] seqPc;
    logic [31:0] nxt;
    string tag;
    opcode = op; funct = fn; offset = off; target = tgt; rsVal = rs; rtVal = rt; stall = st;
    #1;
    seqPc = mPc + 32'd4;
    check("R6", "linkAddr", linkAddr, seqPc);
    check("R8", "linkWe", {31'd0, linkWe}, {31'd0, (op == 6'd3) && !st});
    if (st) begin
      nxt = mPc; tag = "R9";
    end else if (op == 6'd4) begin
      nxt = (rs == rt) ? seqPc + 32'($signed(off)) * 32'd4 : seqPc; tag = "R3";
    end else if (op == 6'd5) begin
      nxt = (rs != rt) ? seqPc + 32'($signed(off)) * 32'd4 : seqPc; tag = "R4";
    end else if (op == 6'd2 || op == 6'd3) begin
      nxt = {seqPc[31:28], tgt, 2'b00}; tag = (op == 6'd2) ? "R5" : "R6";
    end else if (op == 6'd0 && fn == 6'd8) begin
      nxt = rs; tag = "R7";
    end else begin
      nxt = seqPc; tag = "R2";
    end
    @(negedge clk);
    mPc = nxt;
    check(tag, "pc after edge (R10)", pc, mPc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    opcode = 6'd2; target = 26'h3FFFFFF;
    repeat (2) @(negedge clk);
    check("R1", "pc in reset", pc, 32'h0);
    rstN = 1'b1;
    mPc = 32'h0;
    @(negedge clk);
    mPc = {4'h0, 26'h3FFFFFF, 2'b00};
    check("R10", "first jump after reset", pc, mPc);

    step(6'd13, 6'd0, 16'h0, 26'h0, 32'h1, 32'h2, 1'b0);            // R2 other opcode
    step(6'd0, 6'd32, 16'h0, 26'h0, 32'h1, 32'h2, 1'b0);            // R2 funct not 8
    step(6'd8, 6'd8, 16'h0, 26'h0, 32'h40, 32'h2, 1'b0);            // R2 funct 8 wrong opcode
    step(6'd0, 6'd8, 16'h0, 26'h0, 32'h0000_1000, 32'h0, 1'b0);     // R7
    step(6'd4, 6'd0, 16'h0010, 26'h0, 32'h5, 32'h5, 1'b0);          // R3 taken forward
    step(6'd4, 6'd0, 16'hFFF0, 26'h0, 32'h5, 32'h6, 1'b0);          // R3 not taken
    step(6'd4, 6'd0, 16'hFFF0, 26'h0, 32'h9, 32'h9, 1'b0);          // R3 taken backward
    step(6'd5, 6'd0, 16'h7FFF, 26'h0, 32'h1, 32'h2, 1'b0);          // R4 max positive
    step(6'd5, 6'd0, 16'h8000, 26'h0, 32'h3, 32'h3, 1'b0);          // R4 equal, not taken
    step(6'd5, 6'd0, 16'h8000, 26'h0, 32'h3, 32'h4, 1'b0);          // R4 most negative
    step(6'd0, 6'd8, 16'h0, 26'h0, 32'h8000_0000, 32'h0, 1'b0);     // R7 into region 8
    step(6'd2, 6'd0, 16'h0, 26'h0000123, 32'h0, 32'h0, 1'b0);       // R5 keeps region 8
    step(6'd3, 6'd0, 16'h0, 26'h2AAAAAA, 32'h0, 32'h0, 1'b0);       // R6 call
    step(6'd0, 6'd8, 16'h0, 26'h0, 32'hFFFF_FFFC, 32'h0, 1'b0);     // R7 top word
    step(6'd2, 6'd0, 16'h0, 26'h0000040, 32'h0, 32'h0, 1'b0);       // R5 region from wrapped pc+4
    step(6'd3, 6'd0, 16'h0, 26'h1, 32'h0, 32'h0, 1'b1);             // R9 stalled call, R8 no link
    step(6'd4, 6'd0, 16'h0100, 26'h0, 32'h7, 32'h7, 1'b1);          // R9 stalled branch
    step(6'd0, 6'd8, 16'h0, 26'h0, 32'h1234_5678, 32'h0, 1'b1);     // R9 stalled indirect

    for (int i = 0; i < 1500; i++) begin
      logic [5:0] ops [8] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd13, 6'd35};
      logic [5:0] fns [3] = '{6'd8, 6'd32, 6'd34};
      logic [31:0] a = $urandom;
      logic [31:0] b = ($urandom_range(0, 1) == 0) ? a : $urandom;
      step(ops[$urandom_range(0, 7)], fns[$urandom_range(0, 2)], 16'($urandom), 26'($urandom),
           {a[31:2], 2'b00}, b, ($urandom_range(0, 7) == 0));
    end

    rstN = 1'b0;
    #1;
    check("R1", "pc after mid-run reset", pc, 32'h0);
    @(negedge clk);
    check("R1", "pc held in reset", pc, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule